// File: doc/BRIEF.md
# Freewheeling Rectifier Gate Driver with Predictive Turn-Off

This block produces the gate command for the freewheeling synchronous rectifier on the secondary side of an isolated converter. Its only timing reference is a slow square wave taken from the transformer secondary. The primary switch is on while that wave is high. The freewheeling rectifier may conduct only while the wave is low. Its gate must also be released before the next rising edge arrives. If the gate were released in reaction to the edge, the release would come too late and short the secondary.

The block samples the sync wave with a fast internal clock and measures each full switching period in clock ticks. It uses that measurement in the following period to drop the gate a selectable number of ticks before the predicted next rising edge. Two counters share the work and exchange roles at every rising edge. One counts up to measure the current period. The other counts down from the previous period's length, and its value is the number of ticks left until the predicted edge. When the period changes, the block stays safe: a rising edge that comes early forces the gate off, and a late one only shortens the on-time for that one cycle.

Top module: `sr_anticipate_drv`

## Requirements
- R1: `gate_o` is low while `rst_ni` is low. After reset it stays low until two rising edges of `sync_i` have been seen. The first turn-on falls in the period that starts at the second rising edge.
- R2: `sync_i` passes through two flops before it is used. Take a period of N = H + L cycles, with `sync_i` high for H cycles and then low for L cycles, following a period of the same length. `gate_o` goes high at the third clock edge after the first edge that samples `sync_i` low. It stays high for exactly L − X − 1 cycles, or for none if that value is not positive.
- R3: The anticipation X in ticks is set by `ant_sel_i`: 00 gives 2, 01 gives 4, 10 gives 6 and 11 gives 8. In steady state, the last high cycle of `gate_o` ends X − 1 edges before the edge that first samples the next rising level of `sync_i`.
- R4: If a period is shorter than the one before and the count has not run out, `gate_o` is low from the second edge after the first edge that samples `sync_i` high.
- R5: If a period is longer than the one before, `gate_o` falls at the point the previous length predicts: it is high for Nprev − X − H − 1 cycles. The next period uses the newly measured length.
- R6: If the high time H of a period is at least Nprev − X − 1, `gate_o` stays low for that whole period.
- R7: The period counters are 12 bits wide and saturate at 4095. If a measured period reaches that value, `gate_o` stays low for the whole of the following period. Normal operation resumes after the next period that is measured without saturation.
- R8: `gate_o` is never high in a cycle whose synchronized sync level is high. That level is the value of `sync_i` two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast internal clock; all timing is counted in its ticks |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Switching-frequency square wave from the transformer secondary (asynchronous) |
| ant_sel_i | input | 2 | Selects the anticipation: 2, 4, 6 or 8 ticks |
| gate_o | output | 1 | Freewheeling rectifier gate command, high means on |

## Verification
The assertions check several properties on every cycle. The edge detector emits single-cycle pulses. At each rising edge the up-counter's value passes to the down role, less one. The down count never rises between edges. A saturated or first measurement leaves the next period invalid. The gate is high only in a valid period and only while the remaining count is above the anticipation. The gate is low in every rising-edge cycle.

Only the directed scenarios can show the actual on-time lengths in ticks. They also show that each select code gives the right anticipation, that the block adapts over short, long, too-high-duty and saturated periods, and that the gate follows the sync pin with the stated synchronizer latency.

// File: rtl/sr_ant_pkg.sv
package sr_ant_pkg;

  typedef enum logic {
    CNT_A = 1'b0,
    CNT_B = 1'b1
  } cnt_role_e;

  // anticipation ticks: step * (sel + 1)
  function automatic int unsigned ant_ticks(input logic [1:0] sel, input int unsigned step);
    return step * (32'(sel) + 32'd1);
  endfunction

endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;

  a_r2_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/sr_period_tracker.sv
module sr_period_tracker
  import sr_ant_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] down_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam int unsigned      N_CNT   = 2;

  logic [CNT_W-1:0] cnt_q [N_CNT];
  logic [CNT_W-1:0] cnt_d [N_CNT];
  cnt_role_e        up_role_q;
  logic             up_idx;
  logic             seen_q;
  logic             valid_q;
  logic [CNT_W-1:0] up_cnt;

  assign up_idx = (up_role_q == CNT_B);
  assign up_cnt = cnt_q[up_idx];
  assign down_o = cnt_q[~up_idx];
  assign valid_o = valid_q;

  for (genvar k = 0; k < N_CNT; k++) begin : g_cnt
    logic             is_up;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] dec;
    assign is_up = (up_idx == 1'(k));
    assign inc   = (cnt_q[k] == CNT_MAX) ? cnt_q[k] : cnt_q[k] + CNT_ONE;
    assign dec   = (cnt_q[k] == '0) ? '0 : cnt_q[k] - CNT_ONE;
    // at an edge the measuring counter turns into the countdown, the other restarts
    assign cnt_d[k] = rise_i ? (is_up ? dec : CNT_ONE) : (is_up ? inc : dec);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '{default: '0};
      up_role_q <= CNT_A;
      seen_q    <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (rise_i) begin
        up_role_q <= (up_role_q == CNT_A) ? CNT_B : CNT_A;
        seen_q    <= 1'b1;
        valid_q   <= seen_q && (up_cnt != CNT_MAX);
      end
    end
  end

  a_r2_swap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && (up_cnt != '0) |=> down_o == $past(up_cnt) - CNT_ONE);

  a_r5_down_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rise_i) |-> down_o <= $past(down_o));

  a_r7_sat_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && (up_cnt == CNT_MAX) |=> !valid_o);

  a_r1_first_rise_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && !seen_q |=> !valid_o);

endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import sr_ant_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned ANT_STEP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             level_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] down_i,
  input  logic [1:0]       ant_sel_i,
  output logic             gate_o
);

  logic [CNT_W-1:0] ant_x;
  logic [CNT_W-1:0] thr;
  logic             gate_q;

  assign ant_x = CNT_W'(ant_ticks(ant_sel_i, ANT_STEP));
  // one extra tick covers the output register stage
  assign thr   = ant_x + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= valid_i & ~level_i & (down_i > thr);
  end

  // mask by the synchronized level so an early edge cuts the gate in the same cycle
  assign gate_o = gate_q & ~level_i;

  a_r1_gate_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> valid_i);

  a_r3_gate_above_ant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o && $stable(ant_sel_i) |-> down_i > ant_x);

endmodule

// File: rtl/sr_anticipate_drv.sv
module sr_anticipate_drv #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 12,
  parameter int unsigned ANT_STEP    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic [1:0] ant_sel_i,
  output logic       gate_o
);

  logic             sync_lvl;
  logic             sync_rise;
  logic [CNT_W-1:0] down_cnt;
  logic             meas_valid;

  sr_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sync_i),
    .level_o (sync_lvl),
    .rise_o  (sync_rise)
  );

  sr_period_tracker #(
    .CNT_W (CNT_W)
  ) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (sync_rise),
    .down_o  (down_cnt),
    .valid_o (meas_valid)
  );

  sr_gate_ctrl #(
    .CNT_W    (CNT_W),
    .ANT_STEP (ANT_STEP)
  ) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (sync_lvl),
    .valid_i   (meas_valid),
    .down_i    (down_cnt),
    .ant_sel_i (ant_sel_i),
    .gate_o    (gate_o)
  );

  a_r4_off_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rise |-> !gate_o);

endmodule

// File: tb/test_sr_anticipate_drv.sv
module test_sr_anticipate_drv;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic [1:0] ant_sel_i = 2'b00;
  logic       gate_o;

  sr_anticipate_drv i_sr_anticipate_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .ant_sel_i (ant_sel_i),
    .gate_o    (gate_o)
  );

  always #4 clk_i = ~clk_i;

  localparam int HIST = 8192;
  bit hist [HIST];
  bit drv  [HIST];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sample the output, then drive sync_i for the coming edge
  task automatic step(input bit v);
    @(negedge clk_i);
    hist[cyc] = gate_o;
    drv[cyc]  = v;
    sync_i    = v;
    cyc++;
  endtask

  task automatic run_period(input int h, input int l, output int r);
    r = cyc;
    repeat (h) step(1'b1);
    repeat (l) step(1'b0);
  endtask

  function automatic int count_hi(input int a, input int b);
    int n = 0;
    for (int j = a; j <= b; j++) n += int'(hist[j]);
    return n;
  endfunction

  // expected high samples: [r+h+3, r+min(nprev-x, ncur)+1]
  task automatic check_period(input string req, input int r, input int h, input int ncur,
                              input int nprev, input int x, input bit valid);
    int first = h + 3;
    int last  = ((nprev - x) < ncur ? (nprev - x) : ncur) + 1;
    int exp   = (valid && last >= first) ? last - first + 1 : 0;
    chk(req, "on-cycle count", count_hi(r + 2, r + ncur + 1), exp);
    if (exp > 0)
      chk(req, "on/off edge pattern",
          int'({hist[r+first-1], hist[r+first], hist[r+last], hist[r+last+1]}), 4'b0110);
  endtask

  task automatic t_reset();
    int r0;
    repeat (3) step(1'b0);
    chk("R1", "gate in reset", int'(gate_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    r0 = cyc;
    repeat (10) step(1'b0);
    chk("R1", "gate idle after reset", count_hi(r0, cyc - 1), 0);
  endtask

  task automatic t_warmup();
    int r1, r2, r3;
    ant_sel_i = 2'b00;
    run_period(20, 40, r1);
    run_period(20, 40, r2);
    run_period(20, 40, r3);
    check_period("R1", r1, 20, 60, 60, 2, 1'b0);
    check_period("R2", r2, 20, 60, 60, 2, 1'b1);
    check_period("R2", r3, 20, 60, 60, 2, 1'b1);
  endtask

  task automatic t_anticipation();
    int r;
    for (int s = 1; s < 4; s++) begin
      ant_sel_i = 2'(s);
      run_period(20, 40, r);
      check_period("R3", r, 20, 60, 60, 2 * (s + 1), 1'b1);
    end
  endtask

  task automatic t_period_change();
    int rs, rl, rn;
    ant_sel_i = 2'b11;
    run_period(20, 30, rs);
    run_period(20, 40, rl);
    run_period(20, 40, rn);
    check_period("R4", rs, 20, 50, 60, 8, 1'b1);
    chk("R4", "gate after early edge", int'(hist[rl+2]), 0);
    check_period("R5", rl, 20, 60, 50, 8, 1'b1);
    check_period("R5", rn, 20, 60, 60, 8, 1'b1);
  endtask

  task automatic t_ontime();
    int ra, rb, rc;
    run_period(50, 10, ra);
    run_period(51, 9, rb);
    run_period(20, 40, rc);
    check_period("R6", ra, 50, 60, 60, 8, 1'b1);
    check_period("R6", rb, 51, 60, 60, 8, 1'b1);
    chk("R6", "gate count with long high time", count_hi(rb, rb + 59), 0);
    check_period("R6", rc, 20, 60, 60, 8, 1'b1);
  endtask

  task automatic t_saturate();
    int ra, rb, rc, rd;
    run_period(20, 4100, ra);
    run_period(20, 40, rb);
    run_period(20, 40, rc);
    run_period(20, 40, rd);
    check_period("R7", ra, 20, 4120, 60, 8, 1'b1);
    check_period("R7", rb, 20, 60, 4095, 8, 1'b0);
    check_period("R7", rc, 20, 60, 60, 8, 1'b1);
  endtask

  task automatic t_level_rule();
    int bad = 0;
    for (int j = 2; j < cyc; j++)
      if (hist[j] && drv[j-2]) bad++;
    chk("R8", "gate high while synced level high", bad, 0);
  endtask

  initial begin
    t_reset();
    t_warmup();
    t_anticipation();
    t_period_change();
    t_ontime();
    t_saturate();
    t_level_rule();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule